// File: doc/BRIEF.md
# DC-balance deserializer decoder

This block is the digital receive half of a three-lane serial link. It runs on the bit-rate clock and takes one bit per cycle from each data lane, together with the sampled level of the forwarded clock lane. The forwarded clock goes low once per parallel word. The block uses that edge to place the word boundary. After four boundaries in a row arrive at the expected spacing, it declares lock.

Two framings are supported, and a mode input selects between them. In the plain framing each lane carries 7 data bits per word. In the balanced framing each lane carries 9 bits per word: 7 data bits and then two flag bits. The flag bits tell the receiver whether the transmitter complemented that lane's group to limit the running disparity. The block removes the flags, restores the original polarity and marks any group whose flags are not complementary. The decoded 21-bit word leaves through a register together with a recovered parallel clock. A parameter chooses whether that clock's rising or falling edge is the strobe edge. A power-down input releases every parallel output.

Top module: `dcb_deser`

## Requirements
- R1: With `bal_mode` = 1 a word spans 9 bit periods per lane. With `bal_mode` = 0 it spans 7, and plain words appear on `par_data` unaltered, with `frame_err` = 0.
- R2: The first bit of a word is the first bit period in which `clk_lane_bit` reads 0 after having read 1.
- R3: `locked` rises at the bit-clock edge that samples the fourth consecutive boundary landing exactly one word length after the previous position. A boundary at any other spacing, or a missing boundary, clears the count; a misplaced boundary restarts it at one.
- R4: Word bit k (k = 0..6) of lane L is presented on `par_data[7*L + k]`, and lane bit k is the k-th bit received after the boundary.
- R5: In balanced mode, lane bit 7 is flag A and lane bit 8 is flag B. A=1,B=0 means the lane's 7 data bits are complemented before output. A=0,B=1 means they are passed as received.
- R6: In balanced mode, a lane whose two flags are equal passes its data uninverted and sets `frame_err` to 1 for that word. Other lanes of the same word still decode normally.
- R7: `par_data` and `frame_err` are registered. They change only at the edge that samples a word's last bit, and only while `locked` is 1; otherwise they hold.
- R8: With `STROBE_RISING` = 1, `par_clk` is 0 after the edges sampling word positions below N/2 and 1 from position N/2 on (N = 9 or 7, N/2 rounded down). With `STROBE_RISING` = 0 it is the complement. `par_data` never changes at the strobe edge.
- R9: While `pwr_down` is 1, `par_data` and `par_clk` are not driven. When `pwr_down` returns to 0, the held word reappears.
- R10: Synchronous reset clears `par_data`, `frame_err` and `locked` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| bal_mode | input | 1 | 1 selects 9-bit balanced words, 0 selects 7-bit plain words |
| pwr_down | input | 1 | Releases the parallel outputs while high |
| clk_lane_bit | input | 1 | Sampled level of the forwarded clock lane |
| lane_bits | input | LANES | One received bit per data lane |
| par_data | output | LANES*7 | Decoded parallel word |
| par_clk | output | 1 | Recovered parallel clock / output strobe |
| locked | output | 1 | Word boundary found and consistent |
| frame_err | output | 1 | Equal flag pair seen on some lane of the current word |

## Verification
The assertions assume that `bal_mode` does not change in the middle of a word and that `clk_lane_bit` and `lane_bits` are stable for a whole bit period. They also assume reset lasts at least one clock edge. The stimulus changes every input only on the falling clock edge. It switches the mode only at a word boundary and makes each clock-lane pattern low first and high last, so each word contains exactly one falling transition. The balanced words alternate low times of 5 and 4 bits. The only deliberate boundary violation is one truncated word, used to break lock.

// File: rtl/ddes_pkg.sv
package ddes_pkg;
  localparam int DATA_W      = 7;
  localparam int FLAG_W      = 2;
  localparam int FRAME_PLAIN = DATA_W;
  localparam int FRAME_BAL   = DATA_W + FLAG_W;
  localparam int FRAME_MAX   = FRAME_BAL;
  localparam int POS_W       = $clog2(FRAME_MAX);

  typedef logic [POS_W-1:0] pos_t;

  localparam pos_t POS_LAST_BAL   = pos_t'(FRAME_BAL - 1);
  localparam pos_t POS_LAST_PLAIN = pos_t'(FRAME_PLAIN - 1);
  localparam pos_t POS_MID_BAL    = pos_t'(FRAME_BAL / 2);
  localparam pos_t POS_MID_PLAIN  = pos_t'(FRAME_PLAIN / 2);
endpackage

// File: rtl/ddes_framer.sv
module ddes_framer
  import ddes_pkg::*;
#(
  parameter int LOCK_FRAMES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bal_mode,
  input  logic clk_lane_bit,
  output pos_t cur_pos,
  output logic frame_last,
  output logic fall,
  output logic locked
);
  localparam int CNT_W = $clog2(LOCK_FRAMES + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LOCK_FRAMES);

  logic             clk_prev;
  pos_t             pos_q;
  pos_t             last_pos;
  logic             at_wrap;
  logic [CNT_W-1:0] cnt_q;

  // Position of the bit presented this cycle; a falling clock-lane
  // transition forces position zero, otherwise the counter free-runs.
  always_comb begin
    last_pos = bal_mode ? POS_LAST_BAL : POS_LAST_PLAIN;
    fall     = clk_prev & ~clk_lane_bit;
    at_wrap  = (pos_q >= last_pos);
    if (fall || at_wrap) cur_pos = '0;
    else                 cur_pos = pos_q + pos_t'(1);
    frame_last = (cur_pos == last_pos);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_prev <= 1'b0;
      pos_q    <= POS_LAST_BAL;
      cnt_q    <= '0;
    end else begin
      clk_prev <= clk_lane_bit;
      pos_q    <= cur_pos;
      if (fall && at_wrap) begin
        if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
      end else if (fall) begin
        cnt_q <= CNT_W'(1);
      end else if (at_wrap) begin
        cnt_q <= '0;
      end
    end
  end

  assign locked = (cnt_q == CNT_TOP);
endmodule

// File: rtl/ddes_lane_cap.sv
module ddes_lane_cap
  import ddes_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_in,
  input  pos_t                 cur_pos,
  output logic [FRAME_MAX-1:0] frame_vec
);
  logic [FRAME_MAX-1:0] held_q;

  for (genvar i = 0; i < FRAME_MAX; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                      held_q[i] <= 1'b0;
      else if (cur_pos == pos_t'(i)) held_q[i] <= bit_in;
    end
    // The slot being received this cycle is taken straight from the pin.
    assign frame_vec[i] = (cur_pos == pos_t'(i)) ? bit_in : held_q[i];
  end
endmodule

// File: rtl/ddes_lane_dec.sv
module ddes_lane_dec
  import ddes_pkg::*;
(
  input  logic [FRAME_MAX-1:0] frame_vec,
  input  logic                 bal_mode,
  output logic [DATA_W-1:0]    data_out,
  output logic                 flag_err
);
  logic flag_a;
  logic flag_b;
  logic flip;

  always_comb begin
    flag_a   = frame_vec[DATA_W];
    flag_b   = frame_vec[DATA_W+1];
    flip     = bal_mode & flag_a & ~flag_b;
    flag_err = bal_mode & (flag_a == flag_b);
    data_out = frame_vec[DATA_W-1:0] ^ {DATA_W{flip}};
  end
endmodule

// File: rtl/dcb_deser.sv
module dcb_deser
  import ddes_pkg::*;
#(
  parameter int LANES         = 3,
  parameter int LOCK_FRAMES   = 4,
  parameter bit STROBE_RISING = 1'b1,
  localparam int OUT_W        = LANES * DATA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bal_mode,
  input  logic             pwr_down,
  input  logic             clk_lane_bit,
  input  logic [LANES-1:0] lane_bits,
  output logic [OUT_W-1:0] par_data,
  output logic             par_clk,
  output logic             locked,
  output logic             frame_err
);
  pos_t             cur_pos;
  pos_t             mid_pos;
  logic             frame_last_w;
  logic             fall_w;
  logic [OUT_W-1:0] word_d;
  logic [LANES-1:0] lane_err;
  logic [OUT_W-1:0] word_q;
  logic             err_q;
  logic             pclk_q;

  ddes_framer #(.LOCK_FRAMES(LOCK_FRAMES)) u_framer (
    .clk          (clk),
    .rst          (rst),
    .bal_mode     (bal_mode),
    .clk_lane_bit (clk_lane_bit),
    .cur_pos      (cur_pos),
    .frame_last   (frame_last_w),
    .fall         (fall_w),
    .locked       (locked)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [FRAME_MAX-1:0] vec;
    ddes_lane_cap u_cap (
      .clk       (clk),
      .rst       (rst),
      .bit_in    (lane_bits[l]),
      .cur_pos   (cur_pos),
      .frame_vec (vec)
    );
    ddes_lane_dec u_dec (
      .frame_vec (vec),
      .bal_mode  (bal_mode),
      .data_out  (word_d[l*DATA_W +: DATA_W]),
      .flag_err  (lane_err[l])
    );
  end

  assign mid_pos = bal_mode ? POS_MID_BAL : POS_MID_PLAIN;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      err_q  <= 1'b0;
      pclk_q <= ~STROBE_RISING;
    end else begin
      if (frame_last_w && locked) begin
        word_q <= word_d;
        err_q  <= |lane_err;
      end
      // Strobe edge lands mid-word, away from the word update.
      if (STROBE_RISING) pclk_q <= (cur_pos >= mid_pos);
      else               pclk_q <= (cur_pos <  mid_pos);
    end
  end

  assign par_data  = pwr_down ? {OUT_W{1'bz}} : word_q;
  assign par_clk   = pwr_down ? 1'bz : pclk_q;
  assign frame_err = err_q;
endmodule

// File: rtl/dcb_deser_chk.sv
module dcb_deser_chk #(
  parameter int OUT_W         = 21,
  parameter bit STROBE_RISING = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             bal_mode,
  input logic             locked,
  input logic             fall,
  input logic             frame_last,
  input logic             err_q,
  input logic             pclk_q,
  input logic [OUT_W-1:0] word_q
);
  localparam logic ACT = STROBE_RISING;

  // R3: lock is only gained at an edge that sampled a boundary
  assert_lock_on_boundary_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(fall));

  // R7: the word moves only after the last bit of a word
  assert_word_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(frame_last)) |-> $stable(word_q));

  // R8: no word change at the strobe edge
  assert_strobe_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && pclk_q == ACT && $past(pclk_q) != ACT) |-> $stable(word_q));

  // R6: a flag error can only come from a balanced word
  assert_err_balanced_only_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(err_q)) |-> $past(bal_mode));
endmodule

bind dcb_deser dcb_deser_chk #(
  .OUT_W         (OUT_W),
  .STROBE_RISING (STROBE_RISING)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bal_mode   (bal_mode),
  .locked     (locked),
  .fall       (fall_w),
  .frame_last (frame_last_w),
  .err_q      (err_q),
  .pclk_q     (pclk_q),
  .word_q     (word_q)
);

// File: tb/dcb_deser_bench.sv
`timescale 1ns/1ps
module dcb_deser_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bal = 1'b1;
  logic        pd  = 1'b0;
  logic        clkbit = 1'b0;
  logic [2:0]  lanes = '0;
  wire  [20:0] pdata;
  wire         pclk;
  wire         lk;
  wire         ferr;

  int checks = 0;
  int errors = 0;
  logic alt = 1'b0;
  logic pcs [9];
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  dcb_deser u_dcb_deser (
    .clk(clk), .rst(rst), .bal_mode(bal), .pwr_down(pd),
    .clk_lane_bit(clkbit), .lane_bits(lanes),
    .par_data(pdata), .par_clk(pclk), .locked(lk), .frame_err(ferr)
  );

  // Vector table: raw lane data, flags {l2A,l2B,l1A,l1B,l0A,l0B}, expected word, expected error
  localparam logic [20:0] VR [5] = '{21'h1ABCDE, 21'h000000, 21'h155555, 21'h012345, 21'h1FFFFF};
  localparam logic [5:0]  VF [5] = '{6'b010101, 6'b101010, 6'b100110, 6'b011101, 6'b000110};
  localparam logic [20:0] VE [5] = '{21'h1ABCDE, 21'h1FFFFF, 21'h0A952A, 21'h012345, 21'h1FFF80};
  localparam logic        VX [5] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drives one word, one bit per falling edge; the clock lane is low first, high last.
  task automatic send_frame(input logic mode, input logic [20:0] raw,
                            input logic [5:0] flags, input int nbits);
    int lowlen;
    lowlen = mode ? (alt ? 5 : 4) : 3;
    if (mode) alt = ~alt;
    for (int k = 0; k < nbits; k++) begin
      bal    = mode;
      clkbit = (k >= lowlen);
      for (int l = 0; l < 3; l++)
        lanes[l] = (k < 7) ? raw[7*l+k] : ((k == 7) ? flags[2*l+1] : flags[2*l]);
      @(negedge clk);
      pcs[k] = pclk;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset word", 32'(pdata), 0);
    check("R10 reset locked", 32'(lk), 0);
    check("R10 reset err", 32'(ferr), 0);
    rst = 1'b0;

    // R2/R3: first word has no preceding fall, then four spaced boundaries
    for (int f = 0; f < 4; f++) send_frame(1'b1, 21'h0F0F0F, 6'b010101, 9);
    check("R3 not yet locked", 32'(lk), 0);
    check("R7 no update before lock", 32'(pdata), 0);
    send_frame(1'b1, 21'h0F0F0F, 6'b010101, 9);
    check("R3 locked after fourth boundary", 32'(lk), 1);
    check("R2 first locked word", 32'(pdata), 32'h0F0F0F);

    // Table walk: R4 lane mapping, R5 inversion flags, R6 equal flags
    for (int i = 0; i < 5; i++) begin
      send_frame(1'b1, VR[i], VF[i], 9);
      check("R4/R5 decoded word", 32'(pdata), 32'(VE[i]));
      check("R6 frame error", 32'(ferr), 32'(VX[i]));
    end

    // R8: strobe position in the last balanced word (rising variant)
    check("R8 pclk pos0", 32'(pcs[0]), 0);
    check("R8 pclk pos3", 32'(pcs[3]), 0);
    check("R8 pclk pos4", 32'(pcs[4]), 1);
    check("R8 pclk pos8", 32'(pcs[8]), 1);

    // R3: truncated word breaks lock; R7: output holds while unlocked
    send_frame(1'b1, 21'h000001, 6'b010101, 8);
    send_frame(1'b1, 21'h000001, 6'b010101, 9);
    check("R3 lock lost on misplaced boundary", 32'(lk), 0);
    check("R7 word held while unlocked", 32'(pdata), 32'h1FFF80);

    // R1: plain 7-bit words, no flags
    for (int j = 0; j < 5; j++) send_frame(1'b0, 21'h0ABCDE ^ 21'(j), 6'b000000, 7);
    check("R1 plain locked", 32'(lk), 1);
    check("R1 plain word", 32'(pdata), 32'h0ABCDA);
    check("R1 plain no error", 32'(ferr), 0);
    check("R8 pclk plain pos2", 32'(pcs[2]), 0);
    check("R8 pclk plain pos3", 32'(pcs[3]), 1);

    // R9: power-down releases outputs
    pd = 1'b1;
    #1;
    checks++;
    if (!(pdata === 21'bz || pdata === 21'b0)) begin
      errors++;
      $display("FAIL R9 data released: actual %h expected z", pdata);
    end
    checks++;
    if (pclk === 1'b1) begin
      errors++;
      $display("FAIL R9 clock released: actual %b expected z", pclk);
    end
    pd = 1'b0;
    #1;
    check("R9 word returns", 32'(pdata), 32'h0ABCDA);

    // R10: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R10 mid-run reset word", 32'(pdata), 0);
    check("R10 mid-run reset locked", 32'(lk), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule